// File: doc/BRIEF.md
# Serial Transmit Master with Mid-Frame Chip-Select Switchover

This block is a transmit-only synchronous serial master for a downstream point-to-point link. One start strobe sends one frame. The frame takes either a command word or a data word, each with its own programmed length. Bits leave least significant first on `sdo`. The serial clock `sck` idles low and is derived from the system clock by a programmable even divider. Data changes while `sck` is low, and the receiver captures each bit on the rising edge.

While a frame is running, the block can move the chip-select drive from a first pattern to a second pattern at a programmed bit boundary. It does this on the capture edge, so the timing margins around the switch stay balanced as the serial clock period changes. Three counts are programmable, each in whole serial-clock periods:

- the setup time from chip-select assertion to the first capture edge;
- the hold time from the last clock fall to chip-select release;
- the dead gap between frames, during which chip-select stays released and the block still reports busy.

An optional leading start bit needs no hardware support: it is just bit 0 of the word.

Top module: `csx_serial_master`

## Requirements
- R1: A frame produces exactly L rising `sck` edges, where L is the selected length clamped to the range 4 to 32 (values below 4 give 4, values above 32 give 32).
- R2: At the k-th rising `sck` edge of a frame (k counted from 0), `sdo` equals bit k of the selected word, so the least significant bit goes first.
- R3: After reset and between frames, `sck` is 0, `sdo` is 0, every bit of `cs_line` is inactive (0 with the default active-high polarity) and `busy` is 0.
- R4: Each `sck` high phase and each low phase between bits lasts `clk_div`+1 system clocks, and `sck` moves only on those divider ticks.
- R5: When 1 <= `switch_bit` < L, `cs_line` shows `cs_first` for bits 0 to `switch_bit`-1. It changes to `cs_second` in the same system clock in which `sck` rises for bit `switch_bit`, and holds `cs_second` to the end of the frame.
- R6: When `switch_bit` is 0, or is at least L, `cs_line` holds `cs_first` for the whole frame.
- R7: From the first cycle in which `cs_line` is asserted to the first rising `sck` edge there are 2·(`setup_per`+1)·(`clk_div`+1) system clocks, so setup is 1 to 16 serial periods.
- R8: From the last falling `sck` edge to the release of `cs_line` there are 2·(`hold_per`+1)·(`clk_div`+1) system clocks, so hold is 1 to 16 serial periods.
- R9: After `cs_line` is released, it stays inactive and `busy` stays 1 for 2·(`gap_per`+1)·(`clk_div`+1) system clocks, so the gap is 1 to 64 serial periods.
- R10: `busy` rises in the cycle after an accepted `start`. A `start` that arrives while `busy` is 1 has no effect: the running frame is unchanged and no further frame follows it.
- R11: `kind` = 0 selects `cmd_word`/`cmd_len`, and `kind` = 1 selects `dat_word`/`dat_len`. All frame settings are captured when `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to send a frame |
| kind | input | 1 | 0 = command frame, 1 = data frame |
| cmd_word | input | 32 | Command frame contents |
| cmd_len | input | 6 | Command frame bit count, before clamping |
| dat_word | input | 32 | Data frame contents |
| dat_len | input | 6 | Data frame bit count, before clamping |
| cs_first | input | 4 | Chip-select pattern for the first part of the frame |
| cs_second | input | 4 | Chip-select pattern after the switchover |
| switch_bit | input | 6 | Bit index at which the switchover occurs |
| setup_per | input | 4 | Setup time in serial periods, minus 1 |
| hold_per | input | 4 | Hold time in serial periods, minus 1 |
| gap_per | input | 6 | Inter-frame gap in serial periods, minus 1 |
| clk_div | input | 4 | Serial half-period in system clocks, minus 1 |
| sck | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data out |
| cs_line | output | 4 | Chip-select lines |
| busy | output | 1 | Frame or gap in progress |

## Verification
The bench checks the switchover at its edges: index 1, index L-1, index 0 and index equal to L. A design that switches one bit early or late, or that does not fall back to the first pattern, shows the wrong pattern at a capture edge. It also checks that the pattern seen just before the switching edge is still the first one. Lengths of 0, 3 and 63 test the clamp, where an unclamped counter would send the wrong number of edges. The extreme setup, hold and gap values (16, 16 and 64 periods) and the divider at 0 and at 15 catch off-by-one period counts. A start strobe injected mid-frame, with new words, length and kind on the inputs, catches a design that reloads or chains a second frame.

// File: rtl/csx_pkg.sv
`timescale 1ns/1ps
package csx_pkg;
   localparam int unsigned MIN_FRAME = 4;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SETUP = 3'd1,
      ST_SHIFT = 3'd2,
      ST_HOLD  = 3'd3,
      ST_DEAD  = 3'd4
   } csx_state_e;
endpackage

// File: rtl/csx_tick_gen.sv
`timescale 1ns/1ps
module csx_tick_gen #(
   parameter int unsigned DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] cnt_q;

   assign tick_o = run_i && (cnt_q == div_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i || tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end

   // After a tick, the next one comes a full half-period later unless the divider is 0.
   assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && tick_o) |=> (!tick_o || div_i == '0));
endmodule

// File: rtl/csx_frame_seq.sv
`timescale 1ns/1ps
module csx_frame_seq
   import csx_pkg::*;
#(
   parameter int unsigned NCS    = 4,
   parameter int unsigned WMAX   = 32,
   parameter int unsigned LEN_W  = 6,
   parameter int unsigned DIV_W  = 4,
   parameter int unsigned DLY_W  = 4,
   parameter int unsigned DEAD_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              kind_i,
   input  logic [WMAX-1:0]   cmd_word_i,
   input  logic [LEN_W-1:0]  cmd_len_i,
   input  logic [WMAX-1:0]   dat_word_i,
   input  logic [LEN_W-1:0]  dat_len_i,
   input  logic [NCS-1:0]    cs_a_i,
   input  logic [NCS-1:0]    cs_b_i,
   input  logic [LEN_W-1:0]  sw_i,
   input  logic [DLY_W-1:0]  setup_i,
   input  logic [DLY_W-1:0]  hold_i,
   input  logic [DEAD_W-1:0] dead_i,
   input  logic [DIV_W-1:0]  div_i,
   input  logic              tick_i,
   output logic              run_o,
   output logic [DIV_W-1:0]  div_o,
   output logic              sck_o,
   output logic              sdo_o,
   output logic [NCS-1:0]    cs_o,
   output logic              busy_o
);
   localparam int unsigned PH_W = ((DEAD_W > DLY_W) ? DEAD_W : DLY_W) + 2;

   csx_state_e        state_q;
   logic [WMAX-1:0]   sh_q;
   logic [LEN_W-1:0]  len_q, len_n, len_raw;
   logic [LEN_W-1:0]  sw_q, bit_q;
   logic              sw_en_q;
   logic [NCS-1:0]    csb_q, cs_q;
   logic [DLY_W-1:0]  setup_q, hold_q;
   logic [DEAD_W-1:0] dead_q;
   logic [DIV_W-1:0]  div_q;
   logic [PH_W-1:0]   ph_q;
   logic              sck_q;

   always_comb begin
      len_raw = kind_i ? dat_len_i : cmd_len_i;
      if (len_raw < LEN_W'(MIN_FRAME))   len_n = LEN_W'(MIN_FRAME);
      else if (len_raw > LEN_W'(WMAX))   len_n = LEN_W'(WMAX);
      else                               len_n = len_raw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sh_q    <= '0;
         len_q   <= LEN_W'(MIN_FRAME);
         sw_q    <= '0;
         sw_en_q <= 1'b0;
         csb_q   <= '0;
         cs_q    <= '0;
         setup_q <= '0;
         hold_q  <= '0;
         dead_q  <= '0;
         div_q   <= '0;
         ph_q    <= '0;
         bit_q   <= '0;
         sck_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (start_i) begin
               state_q <= ST_SETUP;
               sh_q    <= kind_i ? dat_word_i : cmd_word_i;
               len_q   <= len_n;
               sw_q    <= sw_i;
               sw_en_q <= (sw_i != '0) && (sw_i < len_n);
               csb_q   <= cs_b_i;
               cs_q    <= cs_a_i;
               setup_q <= setup_i;
               hold_q  <= hold_i;
               dead_q  <= dead_i;
               div_q   <= div_i;
               ph_q    <= '0;
               bit_q   <= '0;
               sck_q   <= 1'b0;
            end
            ST_SETUP: if (tick_i) begin
               if (ph_q == PH_W'({setup_q, 1'b0})) begin
                  state_q <= ST_SHIFT;
                  ph_q    <= '0;
               end else begin
                  ph_q <= ph_q + PH_W'(1);
               end
            end
            ST_SHIFT: if (tick_i) begin
               if (!sck_q) begin
                  sck_q <= 1'b1;
                  if (sw_en_q && bit_q == sw_q) cs_q <= csb_q;
               end else begin
                  sck_q <= 1'b0;
                  if (bit_q == len_q - LEN_W'(1)) begin
                     state_q <= ST_HOLD;
                     ph_q    <= '0;
                  end else begin
                     sh_q  <= sh_q >> 1;
                     bit_q <= bit_q + LEN_W'(1);
                  end
               end
            end
            ST_HOLD: if (tick_i) begin
               if (ph_q == PH_W'({hold_q, 1'b1})) begin
                  state_q <= ST_DEAD;
                  cs_q    <= '0;
                  ph_q    <= '0;
               end else begin
                  ph_q <= ph_q + PH_W'(1);
               end
            end
            ST_DEAD: if (tick_i) begin
               if (ph_q == PH_W'({dead_q, 1'b1})) begin
                  state_q <= ST_IDLE;
                  ph_q    <= '0;
               end else begin
                  ph_q <= ph_q + PH_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q != ST_IDLE);
   assign run_o  = busy_o;
   assign div_o  = div_q;
   assign sck_o  = sck_q;
   assign cs_o   = cs_q;
   assign sdo_o  = (state_q == ST_SETUP || state_q == ST_SHIFT || state_q == ST_HOLD) ? sh_q[0] : 1'b0;

   assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE || state_q == ST_DEAD) |-> (!sck_q && cs_q == '0));

   assert_sck_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sck_q) |-> $past(tick_i));

   assert_switch_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SHIFT && $past(state_q) == ST_SHIFT && !$stable(cs_q)) |-> $rose(sck_q));

   assert_len_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |-> (len_q >= LEN_W'(MIN_FRAME) && len_q <= LEN_W'(WMAX)));

   assert_bit_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SHIFT) |-> (bit_q < len_q));

   assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && start_i) |=> ($stable(len_q) && $stable(csb_q) && $stable(sw_q)));
endmodule

// File: rtl/csx_serial_master.sv
`timescale 1ns/1ps
module csx_serial_master #(
   parameter int unsigned NCS           = 4,
   parameter int unsigned WMAX          = 32,
   parameter int unsigned DIV_W         = 4,
   parameter int unsigned DLY_W         = 4,
   parameter int unsigned DEAD_W        = 6,
   parameter bit          CS_ACTIVE_LOW = 1'b0,
   localparam int unsigned LEN_W        = $clog2(WMAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              kind,
   input  logic [WMAX-1:0]   cmd_word,
   input  logic [LEN_W-1:0]  cmd_len,
   input  logic [WMAX-1:0]   dat_word,
   input  logic [LEN_W-1:0]  dat_len,
   input  logic [NCS-1:0]    cs_first,
   input  logic [NCS-1:0]    cs_second,
   input  logic [LEN_W-1:0]  switch_bit,
   input  logic [DLY_W-1:0]  setup_per,
   input  logic [DLY_W-1:0]  hold_per,
   input  logic [DEAD_W-1:0] gap_per,
   input  logic [DIV_W-1:0]  clk_div,
   output logic              sck,
   output logic              sdo,
   output logic [NCS-1:0]    cs_line,
   output logic              busy
);
   generate
      if (WMAX < csx_pkg::MIN_FRAME) begin : g_bad_wmax
         $error("WMAX must be at least the minimum frame length");
      end
      if (NCS < 1 || DIV_W < 1 || DLY_W < 1 || DEAD_W < 1) begin : g_bad_width
         $error("all field widths must be at least one bit");
      end
   endgenerate

   logic             run, tick;
   logic [DIV_W-1:0] div_live;
   logic [NCS-1:0]   cs_act;

   csx_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run),
      .div_i  (div_live),
      .tick_o (tick)
   );

   csx_frame_seq #(
      .NCS(NCS), .WMAX(WMAX), .LEN_W(LEN_W),
      .DIV_W(DIV_W), .DLY_W(DLY_W), .DEAD_W(DEAD_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .kind_i     (kind),
      .cmd_word_i (cmd_word),
      .cmd_len_i  (cmd_len),
      .dat_word_i (dat_word),
      .dat_len_i  (dat_len),
      .cs_a_i     (cs_first),
      .cs_b_i     (cs_second),
      .sw_i       (switch_bit),
      .setup_i    (setup_per),
      .hold_i     (hold_per),
      .dead_i     (gap_per),
      .div_i      (clk_div),
      .tick_i     (tick),
      .run_o      (run),
      .div_o      (div_live),
      .sck_o      (sck),
      .sdo_o      (sdo),
      .cs_o       (cs_act),
      .busy_o     (busy)
   );

   generate
      if (CS_ACTIVE_LOW) begin : g_cs_low
         assign cs_line = ~cs_act;
      end else begin : g_cs_high
         assign cs_line = cs_act;
      end
   endgenerate
endmodule

// File: tb/csx_serial_master_bench.sv
`timescale 1ns/1ps
module csx_serial_master_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, kind = 1'b0;
   logic [31:0] cmd_word = '0, dat_word = '0;
   logic [5:0]  cmd_len = '0, dat_len = '0, switch_bit = '0, gap_per = '0;
   logic [3:0]  cs_first = '0, cs_second = '0, setup_per = '0, hold_per = '0, clk_div = '0;
   logic        sck, sdo, busy;
   logic [3:0]  cs_line;
   int errs = 0;
   int checks = 0;

   always #10 clk = ~clk;

   csx_serial_master u_csx_serial_master (
      .clk(clk), .rst_n(rst_n), .start(start), .kind(kind),
      .cmd_word(cmd_word), .cmd_len(cmd_len), .dat_word(dat_word), .dat_len(dat_len),
      .cs_first(cs_first), .cs_second(cs_second), .switch_bit(switch_bit),
      .setup_per(setup_per), .hold_per(hold_per), .gap_per(gap_per), .clk_div(clk_div),
      .sck(sck), .sdo(sdo), .cs_line(cs_line), .busy(busy)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int clamp_len(input logic [5:0] raw);
      if (raw < 4) return 4;
      if (raw > 32) return 32;
      return int'(raw);
   endfunction

   function automatic logic [3:0] exp_cs(input int j, input bit swen, input int sw,
                                         input logic [3:0] a, input logic [3:0] b);
      return (swen && j >= sw) ? b : a;
   endfunction

   task automatic run_frame(input bit k, input logic [31:0] cw, input logic [5:0] cl,
                            input logic [31:0] dw, input logic [5:0] dl,
                            input logic [3:0] a, input logic [3:0] b, input logic [5:0] sw,
                            input logic [3:0] s, input logic [3:0] t, input logic [5:0] d,
                            input logic [3:0] dv, input bit poke);
      int h, elen, n, rises, t_first, t_lr, t_lf, t_off, t_bsy;
      logic [31:0] w;
      logic psck;
      logic [3:0] pcs;
      bit swen, poked;
      h = int'(dv) + 1;
      elen = clamp_len(k ? dl : cl);
      w = k ? dw : cw;
      swen = (sw != 0) && (int'(sw) < elen);
      kind = k; cmd_word = cw; cmd_len = cl; dat_word = dw; dat_len = dl;
      cs_first = a; cs_second = b; switch_bit = sw;
      setup_per = s; hold_per = t; gap_per = d; clk_div = dv;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R10", "busy after accepted start", busy, 1);
      chk(cs_line == a, "R5", "first pattern at assertion", cs_line, a);
      n = 0; rises = 0; psck = 1'b0; pcs = cs_line; poked = 1'b0;
      t_first = -1; t_lr = 0; t_lf = 0; t_off = -1; t_bsy = 0;
      forever begin
         @(negedge clk);
         n++;
         if (start) start = 1'b0;
         if (sck && !psck) begin
            if (rises < 32) chk(sdo == w[rises], "R2 R11", "bit at capture edge", sdo, w[rises]);
            chk(cs_line == exp_cs(rises, swen, int'(sw), a, b), swen ? "R5" : "R6",
                "pattern at capture edge", cs_line, exp_cs(rises, swen, int'(sw), a, b));
            if (swen && rises == int'(sw)) chk(pcs == a, "R5", "pattern just before switch edge", pcs, a);
            if (rises == 0) t_first = n;
            else chk(n - t_lf == h, "R4", "low half period", n - t_lf, h);
            t_lr = n;
            rises++;
            if (poke && rises == 3 && !poked) begin
               start = 1'b1; kind = ~k; cmd_word = ~cw; dat_word = ~dw;
               cmd_len = 6'd9; dat_len = 6'd9; switch_bit = 6'd2; cs_second = ~b;
               poked = 1'b1;
            end
         end
         if (!sck && psck) begin
            chk(n - t_lr == h, "R4", "high half period", n - t_lr, h);
            t_lf = n;
         end
         if (cs_line == 4'd0 && t_off < 0) t_off = n;
         if (t_off >= 0 && cs_line != 4'd0) chk(1'b0, "R9", "chip-select during gap", cs_line, 0);
         psck = sck; pcs = cs_line;
         if (!busy) begin t_bsy = n; break; end
         if (n > 20000) begin chk(1'b0, "R9", "frame watchdog expired", n, 0); break; end
      end
      chk(rises == elen, "R1 R11", "capture edge count", rises, elen);
      chk(t_first == 2 * (int'(s) + 1) * h, "R7", "setup time", t_first, 2 * (int'(s) + 1) * h);
      chk(t_off - t_lf == 2 * (int'(t) + 1) * h, "R8", "hold time", t_off - t_lf, 2 * (int'(t) + 1) * h);
      chk(t_bsy - t_off == 2 * (int'(d) + 1) * h, "R9", "gap time", t_bsy - t_off, 2 * (int'(d) + 1) * h);
      chk(!sck && !sdo && cs_line == 4'd0, "R3", "idle outputs after frame", {sck, sdo, cs_line}, 0);
      if (poke) begin
         repeat (4 * h + 4) @(negedge clk);
         chk(busy == 1'b0 && !sck, "R10", "no frame from ignored start", busy, 0);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errs++; checks++;
      $display("FAIL WD global watchdog expired: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(!sck && !sdo && !busy && cs_line == 4'd0, "R3", "outputs in reset", {sck, sdo, busy, cs_line}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!sck && !sdo && !busy && cs_line == 4'd0, "R3", "outputs after reset", {sck, sdo, busy, cs_line}, 0);
      // Directed corners
      run_frame(1'b0, 32'hA5C3_0F1E, 6'd8, 32'h0, 6'd4, 4'h3, 4'hC, 6'd1, 4'd0, 4'd0, 6'd0, 4'd0, 1'b0);
      run_frame(1'b1, 32'h0, 6'd4, 32'hDEAD_BEEF, 6'd0, 4'h1, 4'h2, 6'd3, 4'd1, 4'd1, 6'd1, 4'd1, 1'b0);
      run_frame(1'b1, 32'h0, 6'd4, 32'h1357_9BDF, 6'd63, 4'h6, 4'h9, 6'd31, 4'd15, 4'd15, 6'd63, 4'd0, 1'b0);
      run_frame(1'b0, 32'h0000_0035, 6'd3, 32'h0, 6'd4, 4'h5, 4'hA, 6'd0, 4'd2, 4'd3, 6'd4, 4'd2, 1'b0);
      run_frame(1'b0, 32'hF0F0_1234, 6'd12, 32'h0, 6'd4, 4'h8, 4'h7, 6'd12, 4'd0, 4'd0, 6'd0, 4'd15, 1'b0);
      run_frame(1'b1, 32'h0, 6'd4, 32'h8000_0001, 6'd32, 4'hF, 4'h1, 6'd40, 4'd1, 4'd0, 6'd2, 4'd0, 1'b0);
      run_frame(1'b0, 32'h2468_ACE0, 6'd15, 32'h1111_1111, 6'd20, 4'h4, 4'h2, 6'd5, 4'd1, 4'd2, 6'd3, 4'd1, 1'b1);
      // Constrained random frames
      for (int i = 0; i < 24; i++) begin
         run_frame(1'($urandom_range(0, 1)), $urandom, 6'($urandom_range(0, 63)),
                   $urandom, 6'($urandom_range(0, 63)),
                   4'($urandom_range(1, 15)), 4'($urandom_range(1, 15)),
                   6'($urandom_range(0, 34)), 4'($urandom_range(0, 15)),
                   4'($urandom_range(0, 15)), 6'($urandom_range(0, 63)),
                   4'($urandom_range(0, 3)), 1'($urandom_range(0, 3) == 0));
      end
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule